// File: doc/BRIEF.md
# In-Order Pipeline Register Scoreboard

This block records which architectural registers are still waiting to be written by instructions in flight. Those are the instructions between the operand-read stage and the result-commit stage of an in-order pipeline. The operand-read stage presents two source register indices on every cycle. It receives a combinational stall whenever either source names a register that an older, uncommitted instruction will still write. While the stall is high it must keep its current instruction and not advance it.

Each issued instruction claims one slot in a small first-in first-out store, kept in program order. An instruction with no destination still takes a slot, with its destination flag clear, so that slots keep lining up with instructions. Slots are released only by the commit stage, always the oldest first, one per cycle.

Instructions found to be on a wrong path are not taken out early. They travel to the commit stage like any other instruction and release their own slot there.

Both the claim port and the release port use valid/ready handshakes. A claim fires when `ins_valid` and `ins_ready` are both high on a rising edge. `ins_ready` is low only when every slot is taken and no release fires in the same cycle. A release fires when `rm_valid` and `rm_ready` are both high. `rm_ready` is low only when the store is empty. Reset is synchronous and active high.

Top module: `reg_scoreboard`

## Requirements
- R1: While and after reset the store is empty: `ins_ready`=1, `rm_ready`=0, and `stall`=0 for every pair of source indices.
- R2: `stall` is 1 when `src_a` or `src_b` equals the destination index of any held slot whose destination flag is set.
- R3: Register index 0 never produces a match, even when a held slot names register 0 as its destination.
- R4: A claim with `ins_has_dst`=0 occupies a slot but never matches any source index.
- R5: With all DEPTH (default 4) slots held and `rm_valid`=0, `ins_ready`=0 and `stall`=1, and a claim offered in that cycle is ignored: the store still holds exactly the same slots.
- R6: A release frees only the oldest held slot. A younger slot holding a different register keeps matching.
- R7: A release offered while the store is empty is ignored: `rm_ready`=0, and the store stays empty.
- R8: When the store is full and a claim and a release are offered in the same cycle, both fire, and the number of held slots stays at DEPTH.
- R9: `stall` reflects the slots held before the current cycle's claim: a source that names the destination being claimed in that same cycle does not cause a stall.
- R10: Two held slots naming the same destination keep causing a stall until both have been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Claim request from the operand-read stage |
| ins_ready | output | 1 | A claim can fire this cycle |
| ins_has_dst | input | 1 | The claiming instruction writes a register |
| ins_dst | input | IDX_W | Destination register index of the claim |
| src_a | input | IDX_W | First source register index to search |
| src_b | input | IDX_W | Second source register index to search |
| stall | output | 1 | Hazard against a held slot, or the store is full |
| rm_valid | input | 1 | Release request from the commit stage |
| rm_ready | output | 1 | A release can fire this cycle (store not empty) |

## Verification
The hardest situation to reach from the ports is a full store in which the write pointer and the read pointer name the same slot, with a claim and a release firing on the same edge. In that case the new entry must replace the departing one. The stimulus fills the store on purpose and then offers both handshakes together. This is repeated at several pointer offsets, and the random phase keeps the claim rate above the release rate so that the store often sits full. Register indices are drawn from a narrow range that includes 0, so that duplicate destinations and index-0 matches occur often.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_DEPTH_DEF = 4;
  localparam int SB_IDX_W_DEF = 5;

  typedef struct packed {
    logic ins;
    logic rm;
  } sb_fire_t;
endpackage

// File: rtl/sb_fifo_ctrl.sv
module sb_fifo_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_req,
  input  logic             rm_req,
  output logic             ins_ok,
  output logic             rm_ok,
  output sb_pkg::sb_fire_t fire,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  assign rm_ok    = (count != '0);
  assign ins_ok   = (count != FULL) || (rm_ok && rm_req);
  assign fire.ins = ins_req && ins_ok;
  assign fire.rm  = rm_req && rm_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (fire.ins) wr_ptr <= bump(wr_ptr);
      if (fire.rm)  rd_ptr <= bump(rd_ptr);
      case ({fire.ins, fire.rm})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sb_entry_array.sv
module sb_entry_array #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  logic                   wr_has,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   clr_en,
  input  logic [PTR_W-1:0]       clr_ptr,
  output logic [DEPTH-1:0]       live,
  output logic [DEPTH*IDX_W-1:0] idx_flat
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             live_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit_wr;
    logic             hit_clr;

    assign hit_wr  = wr_en && (wr_ptr == PTR_W'(g));
    assign hit_clr = clr_en && (clr_ptr == PTR_W'(g));

    // a release and a claim on the same slot: the claim wins
    always_ff @(posedge clk) begin
      if (rst) begin
        live_q <= 1'b0;
        idx_q  <= '0;
      end else if (hit_wr) begin
        live_q <= wr_has;
        idx_q  <= wr_idx;
      end else if (hit_clr) begin
        live_q <= 1'b0;
      end
    end

    assign live[g] = live_q;
    assign idx_flat[g*IDX_W +: IDX_W] = idx_q;
  end
endmodule

// File: rtl/sb_hazard_match.sv
module sb_hazard_match #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 5
) (
  input  logic [DEPTH-1:0]       live,
  input  logic [DEPTH*IDX_W-1:0] idx_flat,
  input  logic [IDX_W-1:0]       src_a,
  input  logic [IDX_W-1:0]       src_b,
  output logic                   hit
);
  logic [DEPTH-1:0] slot_hit;
  logic             a_nz;
  logic             b_nz;

  assign a_nz = (src_a != '0);
  assign b_nz = (src_b != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [IDX_W-1:0] d;
    assign d = idx_flat[g*IDX_W +: IDX_W];
    assign slot_hit[g] = live[g] && ((a_nz && d == src_a) || (b_nz && d == src_b));
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int DEPTH = sb_pkg::SB_DEPTH_DEF,
  parameter int IDX_W = sb_pkg::SB_IDX_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic             ins_has_dst,
  input  logic [IDX_W-1:0] ins_dst,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  output logic             stall,
  input  logic             rm_valid,
  output logic             rm_ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  sb_pkg::sb_fire_t       fire;
  logic [PTR_W-1:0]       wr_ptr;
  logic [PTR_W-1:0]       rd_ptr;
  logic [CNT_W-1:0]       occ_cnt;
  logic [DEPTH-1:0]       live;
  logic [DEPTH*IDX_W-1:0] idx_flat;
  logic                   raw_hit;

  sb_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .ins_req(ins_valid), .rm_req(rm_valid),
    .ins_ok(ins_ready), .rm_ok(rm_ready), .fire(fire),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(occ_cnt)
  );

  sb_entry_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ent_i (
    .clk(clk), .rst(rst), .wr_en(fire.ins), .wr_ptr(wr_ptr),
    .wr_has(ins_has_dst), .wr_idx(ins_dst), .clr_en(fire.rm),
    .clr_ptr(rd_ptr), .live(live), .idx_flat(idx_flat)
  );

  sb_hazard_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) cmp_i (
    .live(live), .idx_flat(idx_flat), .src_a(src_a), .src_b(src_b),
    .hit(raw_hit)
  );

  assign stall = raw_hit || !ins_ready;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             rm_valid,
  input logic             rm_ready,
  input logic             stall,
  input logic [IDX_W-1:0] src_a,
  input logic [IDX_W-1:0] src_b,
  input logic [CNT_W-1:0] occ_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ_cnt <= FULL); // R5
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (occ_cnt == '0 && ins_ready && !rm_ready)); // R1
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (occ_cnt == FULL && !rm_valid) |-> (!ins_ready && stall)); // R5
  AST_PAIR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready && rm_valid && rm_ready) |=> (occ_cnt == $past(occ_cnt))); // R8
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (occ_cnt == '0) |-> (!rm_ready && !stall)); // R7
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (src_a == '0 && src_b == '0 && ins_ready) |-> !stall); // R3
endmodule

bind reg_scoreboard sb_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .rm_valid(rm_valid), .rm_ready(rm_ready), .stall(stall),
  .src_a(src_a), .src_b(src_b), .occ_cnt(occ_cnt)
);

// File: tb/reg_scoreboard_tb_top.sv
`timescale 1ns/1ps
module reg_scoreboard_tb_top;
  localparam int DEPTH = 4;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, ins_has_dst = 1'b0, rm_valid = 1'b0;
  logic [IDX_W-1:0] ins_dst = '0, src_a = '0, src_b = '0;
  logic ins_ready, rm_ready, stall;

  int checks = 0, errors = 0;
  int q_dst[$];
  bit q_has[$];

  always #2.5 clk = ~clk;

  reg_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_has_dst(ins_has_dst), .ins_dst(ins_dst), .src_a(src_a), .src_b(src_b),
    .stall(stall), .rm_valid(rm_valid), .rm_ready(rm_ready)
  );

  function automatic bit mdl_hit(int s1, int s2);
    for (int i = 0; i < q_dst.size(); i++)
      if (q_has[i] && ((s1 != 0 && q_dst[i] == s1) || (s2 != 0 && q_dst[i] == s2)))
        return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit mdl_ins_ready(bit rv);
    return (q_dst.size() < DEPTH) || (rv && q_dst.size() > 0);
  endfunction

  task automatic chk(bit act, bit exp, string what, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // drive one cycle, check the outputs before the edge, then update the model
  task automatic cyc(bit iv, bit hd, int dst, bit rv, int s1, int s2, string tag);
    bit er;
    ins_valid = iv; ins_has_dst = hd; ins_dst = IDX_W'(dst);
    rm_valid = rv; src_a = IDX_W'(s1); src_b = IDX_W'(s2);
    #1;
    er = mdl_ins_ready(rv);
    chk(ins_ready, er, "ins_ready", tag);
    chk(rm_ready, q_dst.size() > 0, "rm_ready", tag);
    chk(stall, mdl_hit(s1, s2) || !er, "stall", tag);
    @(posedge clk);
    if (rv && q_dst.size() > 0) begin
      void'(q_dst.pop_front());
      void'(q_has.pop_front());
    end
    if (iv && er) begin
      q_dst.push_back(dst);
      q_has.push_back(hd);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    while (q_dst.size() > 0) cyc(0, 0, 0, 1, 0, 0, "R6");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5C0A_E0B1));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    #1;
    chk(ins_ready, 1'b1, "ins_ready in reset", "R1");
    chk(rm_ready, 1'b0, "rm_ready in reset", "R1");
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 32; s += 7) cyc(0, 0, 0, 0, s, 31 - s, "R1");

    // R2 / R9: same-cycle claim is not seen, then it is
    cyc(1, 1, 9, 0, 9, 0, "R9");
    cyc(0, 0, 0, 0, 0, 9, "R2");
    cyc(0, 0, 0, 0, 9, 0, "R2");
    // R3: index 0 destination never matches
    cyc(1, 1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, "R3");
    // R4: no-destination claim occupies a slot, never matches
    cyc(1, 0, 12, 0, 12, 12, "R4");
    cyc(0, 0, 0, 0, 12, 12, "R4");
    // now 3 held; fill to 4
    cyc(1, 1, 20, 0, 5, 6, "R2");
    // R5: full, claim refused and ignored
    cyc(1, 1, 7, 0, 1, 2, "R5");
    cyc(1, 1, 7, 0, 7, 0, "R5");
    // R6: release oldest (9), 20 still matches
    cyc(0, 0, 0, 1, 9, 20, "R6");
    cyc(0, 0, 0, 0, 9, 0, "R6");
    cyc(0, 0, 0, 0, 0, 20, "R6");
    // R8: refill and do simultaneous claim+release at several pointer offsets
    for (int k = 0; k < 5; k++) begin
      while (q_dst.size() < DEPTH) cyc(1, 1, 3 + k, 0, 0, 0, "R8");
      cyc(1, 1, 17 + k, 1, 17 + k, 0, "R8");
      cyc(0, 0, 0, 0, 17 + k, 0, "R8");
      cyc(0, 0, 0, 0, 1, 2, "R8");
    end
    drain();
    // R7: release on empty ignored
    cyc(0, 0, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 4, 4, "R7");
    // R10: duplicate destination
    cyc(1, 1, 11, 0, 0, 0, "R10");
    cyc(1, 1, 11, 0, 11, 0, "R10");
    cyc(0, 0, 0, 1, 11, 0, "R10");
    cyc(0, 0, 0, 0, 11, 0, "R10");
    cyc(0, 0, 0, 1, 0, 11, "R10");
    cyc(0, 0, 0, 0, 0, 11, "R10");

    // random phase, claim-heavy, narrow index range
    for (int n = 0; n < 3000; n++) begin
      bit iv, hd, rv;
      iv = ($urandom % 100) < 60;
      rv = ($urandom % 100) < 45;
      hd = ($urandom % 100) < 80;
      cyc(iv, hd, int'($urandom % 8), rv, int'($urandom % 8), int'($urandom % 8), "R2");
    end
    drain();
    // R1: reset mid-stream empties the store
    cyc(1, 1, 6, 0, 0, 0, "R2");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q_dst.delete();
    q_has.delete();
    cyc(0, 0, 0, 0, 6, 6, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule